// File: doc/BRIEF.md
# Banked Shared Memory Crossbar

This block lets a set of processor request ports share one on-chip scratchpad. The scratchpad is split into a number of banks, and consecutive 32-bit words fall into consecutive banks. Each port presents a read or a write with a byte address, write data and four byte-lane enables. It holds that request until the crossbar grants it. The grant is returned in the same cycle the request is presented.

Ports whose requests land in different banks are all served together in one cycle. When several ports aim at one bank, that bank serves exactly one of them per cycle. The choice is made by a per-bank rotating priority pointer, and the other ports stall with their requests pending. Read data comes back on the requesting port one cycle after its grant. Each bank is a single-port synchronous RAM held inside the block. The default build has 16 ports and 32 banks of 64 words each. The bank depth is a parameter that sets the total capacity.

Top module: `shared_bank_xbar`

## Requirements
- R1: The bank of a request is byte-address bits [6:2], and the word within the bank is taken from bits [ADDR_W-1:7]. Address bits [1:0] are ignored.
- R2: A request that no other port sends to the same bank is granted (gnt_o high) in the same cycle it is presented. All such requests in a cycle are granted together.
- R3: In any cycle each bank grants at most one port, and a bank with at least one requester grants exactly one.
- R4: A port is granted only while its req_i is high. An ungranted request stays pending and is granted in a later cycle, once the port holds it.
- R5: Each bank holds a rotating pointer. The winner is the first requesting port found at or after the pointer, in rising port order with wrap-around. After a grant the pointer moves to the port after the winner, and it moves only on a grant. No port waits more than NPORTS-1 cycles.
- R6: A granted read raises rvalid_o on that port exactly one cycle after the grant, with the addressed word on that port's lane of rdata_o. rvalid_o stays low in every other cycle.
- R7: A granted write updates byte lane i (bits 8i+7:8i) of the addressed word only where be_i bit i is 1. Other lanes keep their value.
- R8: A read and a write from different ports to the same bank in the same cycle are serialized: one is granted per cycle.
- R9: Reset is synchronous and active high. It sets every bank pointer to port 0 and clears rvalid_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NPORTS | Per-port request valid |
| wr_i | input | NPORTS | Per-port operation: 1 write, 0 read |
| addr_i | input | NPORTS*ADDR_W | Per-port byte address, port p in bits [p*ADDR_W +: ADDR_W] |
| wdata_i | input | NPORTS*32 | Per-port write data |
| be_i | input | NPORTS*4 | Per-port byte-lane write enables |
| gnt_o | output | NPORTS | Same-cycle grant per port |
| rvalid_o | output | NPORTS | Read data valid, one cycle after a read grant |
| rdata_o | output | NPORTS*32 | Per-port read data |

## Verification
The properties assume that a port whose request was not granted keeps req_i high in the next cycle. They also assume it keeps its operation, address, data and byte enables unchanged, and that no request is raised during reset. Both the bounded-wait check and the pending-request checks rely on these assumptions. The stimulus meets them by giving each port one pending slot, which is filled by the generator, applied every cycle, and emptied only on the grant the reference model predicts. Traffic is spread across all banks, crowded onto two banks, or aimed at a single bank to provoke conflicts.

// File: rtl/sbx_pkg.sv
package sbx_pkg;

    localparam int WORD_W     = 32;
    localparam int LANES      = WORD_W / 8;
    localparam int BYTE_SEL_W = $clog2(LANES);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANES-1:0]  lane_mask_t;

    // Operation carried from a port to the bank that serves it.
    typedef struct packed {
        logic       wr;
        word_t      wdata;
        lane_mask_t lanes;
    } bank_op_t;

    // Index width that stays legal for a count of one.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Replace the selected byte lanes of a stored word.
    function automatic word_t lane_merge(input word_t old_w, input word_t new_w,
                                         input lane_mask_t m);
        word_t r;
        r = old_w;
        for (int i = 0; i < LANES; i++) begin
            if (m[i]) r[8*i +: 8] = new_w[8*i +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/sbx_rr_arbiter.sv
module sbx_rr_arbiter
    import sbx_pkg::*;
#(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req_i,
    output logic [N-1:0] gnt_o
);
    localparam int PW = idx_w(N);

    logic [PW-1:0] ptr_q;
    logic [PW-1:0] win;
    logic          any;

    // Scan from the pointer upward with wrap; the first requester wins.
    always_comb begin
        gnt_o = '0;
        win   = '0;
        any   = 1'b0;
        for (int k = 0; k < N; k++) begin
            if (!any && req_i[(int'(ptr_q) + k) % N]) begin
                any = 1'b1;
                win = PW'((int'(ptr_q) + k) % N);
                gnt_o[(int'(ptr_q) + k) % N] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (any) begin
            ptr_q <= (win == PW'(N - 1)) ? '0 : win + 1'b1;
        end
    end

endmodule

// File: rtl/sbx_bank_ram.sv
module sbx_bank_ram
    import sbx_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int OFF_W = idx_w(DEPTH)
) (
    input  logic             clk,
    input  logic             en_i,
    input  logic [OFF_W-1:0] off_i,
    input  bank_op_t         op_i,
    output word_t            rdata_o
);
    word_t mem [DEPTH];
    word_t rdata_q;

    always_ff @(posedge clk) begin
        if (en_i) begin
            if (op_i.wr) begin
                mem[off_i] <= lane_merge(mem[off_i], op_i.wdata, op_i.lanes);
            end else begin
                rdata_q <= mem[off_i];
            end
        end
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/sbx_bank_slice.sv
module sbx_bank_slice
    import sbx_pkg::*;
#(
    parameter int N     = 16,
    parameter int DEPTH = 64,
    parameter int OFF_W = idx_w(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     hit_i,
    input  logic [OFF_W-1:0] off_i [N],
    input  bank_op_t         op_i  [N],
    output logic [N-1:0]     gnt_o,
    output word_t            rdata_o
);
    logic [N-1:0]     gnt;
    logic [OFF_W-1:0] sel_off;
    bank_op_t         sel_op;

    sbx_rr_arbiter #(.N(N)) u_arb (
        .clk   (clk),
        .rst   (rst),
        .req_i (hit_i),
        .gnt_o (gnt)
    );

    // One-hot grant steers the winning port onto the bank (AND-OR mux).
    always_comb begin
        sel_off = '0;
        sel_op  = '0;
        for (int p = 0; p < N; p++) begin
            if (gnt[p]) begin
                sel_off = sel_off | off_i[p];
                sel_op  = sel_op  | op_i[p];
            end
        end
    end

    sbx_bank_ram #(.DEPTH(DEPTH), .OFF_W(OFF_W)) u_ram (
        .clk     (clk),
        .en_i    (|gnt),
        .off_i   (sel_off),
        .op_i    (sel_op),
        .rdata_o (rdata_o)
    );

    assign gnt_o = gnt;

endmodule

// File: rtl/sbx_rsp_route.sv
module sbx_rsp_route
    import sbx_pkg::*;
#(
    parameter int N  = 16,
    parameter int NB = 32,
    parameter int BW = idx_w(NB)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  gnt_i,
    input  logic [N-1:0]  wr_i,
    input  logic [BW-1:0] bank_i       [N],
    input  word_t         bank_rdata_i [NB],
    output logic [N-1:0]  rvalid_o,
    output word_t         rdata_o      [N]
);
    logic [N-1:0]  pend_q;
    logic [BW-1:0] bank_q [N];

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= gnt_i & ~wr_i;
    end

    always_ff @(posedge clk) begin
        for (int p = 0; p < N; p++) begin
            if (gnt_i[p]) bank_q[p] <= bank_i[p];
        end
    end

    always_comb begin
        for (int p = 0; p < N; p++) begin
            rdata_o[p] = bank_rdata_i[bank_q[p]];
        end
    end

    assign rvalid_o = pend_q;

endmodule

// File: rtl/shared_bank_xbar.sv
module shared_bank_xbar
    import sbx_pkg::*;
#(
    parameter int  NPORTS     = 16,
    parameter int  NBANKS     = 32,
    parameter int  BANK_WORDS = 64,
    localparam int BANK_W     = idx_w(NBANKS),
    localparam int OFF_W      = idx_w(BANK_WORDS),
    localparam int ADDR_W     = BYTE_SEL_W + BANK_W + OFF_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NPORTS-1:0]        req_i,
    input  logic [NPORTS-1:0]        wr_i,
    input  logic [NPORTS*ADDR_W-1:0] addr_i,
    input  logic [NPORTS*WORD_W-1:0] wdata_i,
    input  logic [NPORTS*LANES-1:0]  be_i,
    output logic [NPORTS-1:0]        gnt_o,
    output logic [NPORTS-1:0]        rvalid_o,
    output logic [NPORTS*WORD_W-1:0] rdata_o
);
    logic [ADDR_W-1:0] p_addr  [NPORTS];
    logic [BANK_W-1:0] p_bank  [NPORTS];
    logic [OFF_W-1:0]  p_off   [NPORTS];
    bank_op_t          p_op    [NPORTS];
    word_t             p_rdata [NPORTS];
    logic [NPORTS-1:0] hit     [NBANKS];
    logic [NPORTS-1:0] bgnt    [NBANKS];
    word_t             b_rdata [NBANKS];
    logic              unused_lsb;

    // Word interleave: bank from the bits just above the byte select.
    always_comb begin
        unused_lsb = 1'b0;
        for (int p = 0; p < NPORTS; p++) begin
            p_addr[p] = addr_i[p*ADDR_W +: ADDR_W];
            p_bank[p] = p_addr[p][BYTE_SEL_W +: BANK_W];
            p_off[p]  = p_addr[p][BYTE_SEL_W+BANK_W +: OFF_W];
            p_op[p]   = '{wr:    wr_i[p],
                          wdata: wdata_i[p*WORD_W +: WORD_W],
                          lanes: be_i[p*LANES +: LANES]};
            unused_lsb = unused_lsb ^ (^p_addr[p][BYTE_SEL_W-1:0]);
        end
    end

    always_comb begin
        for (int b = 0; b < NBANKS; b++) begin
            for (int p = 0; p < NPORTS; p++) begin
                hit[b][p] = req_i[p] && (p_bank[p] == BANK_W'(b));
            end
        end
    end

    for (genvar gb = 0; gb < NBANKS; gb++) begin : g_bank
        sbx_bank_slice #(
            .N     (NPORTS),
            .DEPTH (BANK_WORDS),
            .OFF_W (OFF_W)
        ) u_slice (
            .clk     (clk),
            .rst     (rst),
            .hit_i   (hit[gb]),
            .off_i   (p_off),
            .op_i    (p_op),
            .gnt_o   (bgnt[gb]),
            .rdata_o (b_rdata[gb])
        );
    end

    always_comb begin
        gnt_o = '0;
        for (int b = 0; b < NBANKS; b++) begin
            gnt_o = gnt_o | bgnt[b];
        end
    end

    sbx_rsp_route #(.N(NPORTS), .NB(NBANKS), .BW(BANK_W)) u_rsp (
        .clk          (clk),
        .rst          (rst),
        .gnt_i        (gnt_o),
        .wr_i         (wr_i),
        .bank_i       (p_bank),
        .bank_rdata_i (b_rdata),
        .rvalid_o     (rvalid_o),
        .rdata_o      (p_rdata)
    );

    always_comb begin
        for (int p = 0; p < NPORTS; p++) begin
            rdata_o[p*WORD_W +: WORD_W] = p_rdata[p];
        end
    end

endmodule

// File: rtl/sbx_checker.sv
module sbx_checker
    import sbx_pkg::*;
#(
    parameter int NPORTS = 16,
    parameter int NBANKS = 32,
    parameter int ADDR_W = 13
) (
    input logic                     clk,
    input logic                     rst,
    input logic [NPORTS-1:0]        req_i,
    input logic [NPORTS-1:0]        wr_i,
    input logic [NPORTS*ADDR_W-1:0] addr_i,
    input logic [NPORTS*WORD_W-1:0] wdata_i,
    input logic [NPORTS*LANES-1:0]  be_i,
    input logic [NPORTS-1:0]        gnt_o,
    input logic [NPORTS-1:0]        rvalid_o
);
    localparam int BW = idx_w(NBANKS);
    localparam int CW = idx_w(NPORTS) + 1;

    logic [BW-1:0]     bank   [NPORTS];
    logic [NPORTS-1:0] bmask_r [NBANKS];
    logic [NPORTS-1:0] bmask_g [NBANKS];
    logic [NPORTS-1:0] alone;
    logic [CW-1:0]     wait_q [NPORTS];

    always_comb begin
        for (int p = 0; p < NPORTS; p++) begin
            bank[p] = addr_i[p*ADDR_W + BYTE_SEL_W +: BW];
        end
        for (int b = 0; b < NBANKS; b++) begin
            for (int p = 0; p < NPORTS; p++) begin
                bmask_r[b][p] = req_i[p] && (bank[p] == BW'(b));
                bmask_g[b][p] = gnt_o[p] && (bank[p] == BW'(b));
            end
        end
        for (int p = 0; p < NPORTS; p++) begin
            alone[p] = req_i[p];
            for (int q = 0; q < NPORTS; q++) begin
                if (q != p && req_i[q] && bank[q] == bank[p]) alone[p] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int p = 0; p < NPORTS; p++) begin
            if (rst || !req_i[p] || gnt_o[p]) wait_q[p] <= '0;
            else if (wait_q[p] != {CW{1'b1}}) wait_q[p] <= wait_q[p] + 1'b1;
        end
    end

    for (genvar gp = 0; gp < NPORTS; gp++) begin : g_port
        AST_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
            gnt_o[gp] |-> req_i[gp]) else $error("grant without request"); // R4
        AST_PENDING_HELD: assert property (@(posedge clk) disable iff (rst)
            (req_i[gp] && !gnt_o[gp]) |=> (req_i[gp] && $stable(wr_i[gp])
                && $stable(addr_i[gp*ADDR_W +: ADDR_W])
                && $stable(wdata_i[gp*WORD_W +: WORD_W])
                && $stable(be_i[gp*LANES +: LANES])))
            else $error("pending request changed"); // R4
        AST_LONE_REQ_GRANTED: assert property (@(posedge clk) disable iff (rst)
            alone[gp] |-> gnt_o[gp]) else $error("uncontended request stalled"); // R2
        AST_READ_RETURNS: assert property (@(posedge clk) disable iff (rst)
            (gnt_o[gp] && !wr_i[gp]) |=> rvalid_o[gp]) else $error("read data missing"); // R6
        AST_NO_STRAY_RVALID: assert property (@(posedge clk) disable iff (rst)
            !(gnt_o[gp] && !wr_i[gp]) |=> !rvalid_o[gp]) else $error("stray read valid"); // R6
        AST_WAIT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
            wait_q[gp] < CW'(NPORTS)) else $error("port starved"); // R5
    end

    for (genvar gb = 0; gb < NBANKS; gb++) begin : g_bank
        AST_ONE_GNT_PER_BANK: assert property (@(posedge clk) disable iff (rst)
            $countones(bmask_g[gb]) <= 1) else $error("bank granted twice"); // R3
        AST_BANK_SERVES: assert property (@(posedge clk) disable iff (rst)
            (|bmask_r[gb]) |-> (|bmask_g[gb])) else $error("busy bank idle"); // R3
    end

endmodule

bind shared_bank_xbar sbx_checker #(
    .NPORTS (NPORTS),
    .NBANKS (NBANKS),
    .ADDR_W (ADDR_W)
) u_sbx_checker (
    .clk      (clk),
    .rst      (rst),
    .req_i    (req_i),
    .wr_i     (wr_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .be_i     (be_i),
    .gnt_o    (gnt_o),
    .rvalid_o (rvalid_o)
);

// File: tb/shared_bank_xbar_bench.sv
module shared_bank_xbar_bench;
    localparam int NP = 16;
    localparam int NB = 32;
    localparam int BWD = 64;
    localparam int AW = 13;
    localparam int NW = NB * BWD;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NP-1:0]    req = '0;
    logic [NP-1:0]    wr = '0;
    logic [NP*AW-1:0] addr = '0;
    logic [NP*32-1:0] wdata = '0;
    logic [NP*4-1:0]  be = '0;
    logic [NP-1:0]    gnt;
    logic [NP-1:0]    rvalid;
    logic [NP*32-1:0] rdata;

    always #5 clk = ~clk;

    shared_bank_xbar u_shared_bank_xbar (
        .clk(clk), .rst(rst), .req_i(req), .wr_i(wr), .addr_i(addr),
        .wdata_i(wdata), .be_i(be), .gnt_o(gnt), .rvalid_o(rvalid), .rdata_o(rdata)
    );

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // Reference state
    logic [31:0] mem_m [NW];
    bit          known [NW];
    int          ptr_m [NB];
    bit          pv  [NP];
    bit          pwe [NP];
    logic [AW-1:0] pa [NP];
    logic [31:0] pd [NP];
    logic [3:0]  pb [NP];
    bit          erv [NP];
    logic [31:0] erd [NP];
    bit          erk [NP];
    int          waitc [NP];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int bank_of(input logic [AW-1:0] a);
        return int'(a[6:2]);
    endfunction

    task automatic step();
        bit ng [NP];
        bit nrv [NP];
        logic [31:0] nrd [NP];
        bit nrk [NP];
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            req[p] = pv[p];
            wr[p] = pwe[p];
            addr[p*AW +: AW] = pa[p];
            wdata[p*32 +: 32] = pd[p];
            be[p*4 +: 4] = pb[p];
            ng[p] = 0;
            nrv[p] = 0;
            nrd[p] = '0;
            nrk[p] = 0;
        end
        #1;
        for (int b = 0; b < NB; b++) begin
            for (int k = 0; k < NP; k++) begin
                int p;
                p = (ptr_m[b] + k) % NP;
                if (pv[p] && bank_of(pa[p]) == b) begin
                    ng[p] = 1;
                    break;
                end
            end
        end
        for (int p = 0; p < NP; p++) begin
            chk(gnt[p] === ng[p], $sformatf("R1/R2/R3/R4/R5 grant port %0d", p), 64'(gnt[p]), 64'(ng[p]));
            chk(rvalid[p] === erv[p], $sformatf("R6 rvalid port %0d", p), 64'(rvalid[p]), 64'(erv[p]));
            if (erv[p] && erk[p])
                chk(rdata[p*32 +: 32] === erd[p], $sformatf("R6/R7 read data port %0d", p),
                    64'(rdata[p*32 +: 32]), 64'(erd[p]));
        end
        for (int p = 0; p < NP; p++) begin
            if (ng[p]) begin
                int idx;
                idx = int'(pa[p][AW-1:2]);
                if (pwe[p]) begin
                    for (int i = 0; i < 4; i++)
                        if (pb[p][i]) mem_m[idx][8*i +: 8] = pd[p][8*i +: 8];
                    if (pb[p] == 4'hF) known[idx] = 1;
                end else begin
                    nrv[p] = 1;
                    nrd[p] = mem_m[idx];
                    nrk[p] = known[idx];
                end
                ptr_m[bank_of(pa[p])] = (p + 1) % NP;
                chk(waitc[p] <= NP - 1, $sformatf("R5 wait bound port %0d", p), 64'(waitc[p]), 64'(NP - 1));
                waitc[p] = 0;
                pv[p] = 0;
            end else if (pv[p]) begin
                waitc[p]++;
            end
        end
        for (int p = 0; p < NP; p++) begin
            erv[p] = nrv[p];
            erd[p] = nrd[p];
            erk[p] = nrk[p];
        end
    endtask

    task automatic set_req(input int p, input bit w, input logic [AW-1:0] a,
                           input logic [31:0] d, input logic [3:0] m);
        pv[p] = 1; pwe[p] = w; pa[p] = a; pd[p] = d; pb[p] = m;
    endtask

    task automatic drain();
        for (int n = 0; n < 4 * NP; n++) begin
            bit any;
            any = 0;
            for (int p = 0; p < NP; p++) any |= pv[p];
            if (!any) break;
            step();
        end
        step();
        step();
    endtask

    task automatic fill_random(input int mode);
        for (int p = 0; p < NP; p++) begin
            if (!pv[p] && ($urandom % 4) != 0) begin
                int b;
                logic [AW-1:0] a;
                b = (mode == 0) ? int'($urandom % NB) : (mode == 1) ? int'($urandom % 2) : 5;
                a = {6'($urandom % BWD), 5'(b), 2'($urandom % 4)};
                set_req(p, 1'($urandom % 2), a, $urandom, 4'(($urandom % 15) + 1));
            end
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R4 watchdog actual=running expected=finished");
            report();
        end
    end

    initial begin
        for (int i = 0; i < NW; i++) known[i] = 0;
        for (int b = 0; b < NB; b++) ptr_m[b] = 0;
        for (int p = 0; p < NP; p++) begin
            pv[p] = 0; pwe[p] = 0; pa[p] = '0; pd[p] = '0; pb[p] = '0;
            erv[p] = 0; erd[p] = '0; erk[p] = 0; waitc[p] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R9: idle after reset
        step();
        chk(gnt == '0 && rvalid == '0, "R9 idle outputs after reset", 64'({gnt, rvalid}), 64'(0));

        // R9/R5: all ports hit bank 0, order must start at port 0
        for (int p = 0; p < NP; p++) set_req(p, 1'b1, AW'(p << 7), $urandom, 4'hF);
        for (int s = 0; s < NP; s++) begin
            step();
            chk(gnt == NP'(1 << s), "R9/R5 rotation order from reset", 64'(gnt), 64'(1 << s));
        end
        drain();

        // Fill every word with full-lane writes, no conflicts (R2)
        for (int k = 0; k < NW / NP; k++) begin
            for (int p = 0; p < NP; p++) set_req(p, 1'b1, AW'((p + NP * k) << 2), $urandom, 4'hF);
            step();
            chk(gnt == '1, "R2 distinct banks all granted", 64'(gnt), 64'({NP{1'b1}}));
        end
        drain();

        // R1: same bits 6:2 -> conflict; differ in bit 2 -> both served
        set_req(0, 1'b0, 13'h000, '0, 4'h0);
        set_req(1, 1'b0, 13'h080, '0, 4'h0);
        step();
        chk($countones(gnt) == 1, "R1 bank from bits 6:2 conflict", 64'(gnt), 64'(1));
        drain();
        set_req(0, 1'b0, 13'h000, '0, 4'h0);
        set_req(1, 1'b0, 13'h004, '0, 4'h0);
        step();
        chk(gnt[1:0] == 2'b11, "R1/R2 adjacent words in separate banks", 64'(gnt), 64'(3));
        drain();

        // R8: read and write into bank 3 from two ports
        set_req(2, 1'b1, 13'h00C, 32'h1234_5678, 4'hF);
        set_req(3, 1'b0, 13'h08C, '0, 4'h0);
        step();
        chk($countones(gnt[3:2]) == 1, "R8 read/write same bank first cycle", 64'(gnt[3:2]), 64'(1));
        step();
        chk($countones(gnt[3:2]) == 1, "R8 read/write same bank second cycle", 64'(gnt[3:2]), 64'(1));
        drain();

        // R7: partial write then read back
        begin
            logic [31:0] old_w;
            logic [31:0] exp_w;
            old_w = mem_m[4];
            exp_w = {old_w[31:24], 8'hBB, old_w[15:8], 8'hDD};
            set_req(4, 1'b1, 13'h010, 32'hAABB_CCDD, 4'b0101);
            step();
            drain();
            set_req(4, 1'b0, 13'h010, '0, 4'h0);
            step();
            step();
            chk(rvalid[4] == 1'b1, "R6 rvalid one cycle after read grant", 64'(rvalid[4]), 64'(1));
            chk(rdata[4*32 +: 32] == exp_w, "R7 byte lane merge", 64'(rdata[4*32 +: 32]), 64'(exp_w));
        end
        drain();

        // Random traffic: spread, two hot banks, one hot bank
        for (int mode = 0; mode < 3; mode++) begin
            for (int c = 0; c < 1500; c++) begin
                fill_random(mode);
                step();
            end
            drain();
        end

        done = 1;
        report();
    end

endmodule